// File: doc/BRIEF.md
# Per-Lane PRBS Loopback Tester with Eye Sweep

This block is an at-speed self-test engine for a parallel die-to-die port. A single PRBS-7 source drives every transmit lane at full rate. Each receive lane has its own checker. The checker locks onto whatever pattern arrives, whatever its lane delay, by loading its history from the first seven bits received. It then counts mismatching bits in a saturating counter.

A sweep controller steps the receive sampling-phase code and the voltage-threshold code over their whole grid. At each grid point it waits a settle period and then counts errors over a dwell period. It then stores the count for every lane. When the sweep is finished the stored counts form a per-lane eye map, which software reads one entry at a time.

The block also drives two loopback-enable outputs. One selects a loop from transmitter to receiver inside the same die. The other selects a loop through another port, which may be on a different die. The analog sampler, delay line and comparator are outside the block and see only the codes it outputs.

Top module: `prbs_eye_tester`

## Requirements
- R1: Every transmit lane carries the same bit in each cycle. The stream obeys b[n] = b[n-7] XOR b[n-6], which is the polynomial x^7 + x^6 + 1, and it is never stuck at zero.
- R2: At each grid point a lane checker takes the first 7 bits received after the point starts as its seed and counts nothing for them. A clean lane therefore reads 0 errors whatever its fixed delay.
- R3: During the dwell window, a lane counts one error for each received bit that differs from the XOR of its received bits 7 and 6 cycles earlier. A lane that arrives inverted counts one error per dwell cycle.
- R4: A lane error count stops at 2^CNT_W-1 and holds there.
- R5: All lane counts clear at the start of every grid point. A lane that had errors at one point reads 0 at a later clean point.
- R6: Grid points are visited in raster order with phase as the inner loop. The storage index of a point is threshold*2^PH_W + phase.
- R7: Each grid point lasts settle + dwell + 1 cycles. The settle and dwell values are captured at start, and settle must be at least 8. The done flag rises on the clock edge numbered 1 + 2^(PH_W+TH_W)*(settle+dwell+1), counting the edge that captures start as edge 1.
- R8: busy is high from the cycle after an accepted start until the last point is stored. At that point done goes high. done clears when the next start is accepted.
- R9: A start pulse or a change to cfg_settle or cfg_dwell while busy has no effect on the running sweep.
- R10: rd_count returns, one clock after the read address is applied, the count stored for lane rd_lane at point (rd_phase, rd_thresh).
- R11: While busy, loop_int is high if cfg_ext_loop was 0 at start, and loop_ext is high if it was 1. Both are low while idle, and they are never high together.
- R12: After reset, busy, done, loop_int, loop_ext, phase_code and thresh_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a sweep when idle |
| cfg_ext_loop | input | 1 | 1 selects the cross-port loop, 0 the internal loop |
| cfg_settle | input | TIME_W | Settle cycles per grid point (at least 8) |
| cfg_dwell | input | TIME_W | Counting cycles per grid point (at least 1) |
| tx_lanes | output | LANES | PRBS transmit lanes |
| rx_lanes | input | LANES | Received lanes |
| phase_code | output | PH_W | Sampling-phase code to the receiver |
| thresh_code | output | TH_W | Voltage-threshold code to the receiver |
| loop_int | output | 1 | Internal loopback enable |
| loop_ext | output | 1 | Cross-port loopback enable |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |
| rd_lane | input | LANE_IDX_W | Lane to read |
| rd_phase | input | PH_W | Phase index to read |
| rd_thresh | input | TH_W | Threshold index to read |
| rd_count | output | CNT_W | Stored error count, one clock after the address |

## Verification
The bench builds the block with 4 lanes, 2-bit phase and threshold codes and 4-bit counters. This gives a 16-point grid, so every point of every lane can be read back and compared, and a dwell of 40 cycles drives counters into saturation. The loopback model inverts each lane only at chosen grid points and delays one lane by two cycles. That exercises self-seeding, clearing between points and raster ordering with expected counts computed directly from the codes.

// File: rtl/prbs_eye_pkg.sv
package prbs_eye_pkg;
    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_SETTLE = 2'd1,
        SW_DWELL  = 2'd2,
        SW_STORE  = 2'd3
    } sweep_state_e;

    localparam int PRBS_ORDER = 7;
    localparam int SEED_W     = 3;
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen #(
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LANES-1:0] tx_lanes
);
    import prbs_eye_pkg::*;

    typedef struct packed {
        logic [PRBS_ORDER-1:0] lfsr;
    } gen_regs_t;

    gen_regs_t gen_d, gen_q;

    always_comb begin
        gen_d      = gen_q;
        gen_d.lfsr = {gen_q.lfsr[PRBS_ORDER-2:0],
                      gen_q.lfsr[PRBS_ORDER-1] ^ gen_q.lfsr[PRBS_ORDER-2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '{lfsr: '1};
        else        gen_q <= gen_d;
    end

    // same bit fans out to every lane
    assign tx_lanes = {LANES{gen_q.lfsr[PRBS_ORDER-1]}};

    p_lfsr_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.lfsr != '0);
endmodule

// File: rtl/prbs7_lane_chk.sv
module prbs7_lane_chk #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             rx_bit,
    output logic [CNT_W-1:0] err_cnt
);
    import prbs_eye_pkg::*;

    localparam logic [SEED_W-1:0] SEEDED  = SEED_W'(PRBS_ORDER);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    typedef struct packed {
        logic [PRBS_ORDER-1:0] hist;
        logic [SEED_W-1:0]     seed;
        logic [CNT_W-1:0]      cnt;
    } chk_regs_t;

    chk_regs_t chk_d, chk_q;
    logic      predicted;
    logic      mismatch;

    assign predicted = chk_q.hist[PRBS_ORDER-1] ^ chk_q.hist[PRBS_ORDER-2];
    assign mismatch  = predicted ^ rx_bit;

    always_comb begin
        chk_d = chk_q;
        if (clear) begin
            chk_d.seed = '0;
            chk_d.cnt  = '0;
        end else begin
            chk_d.hist = {chk_q.hist[PRBS_ORDER-2:0], rx_bit};
            if (chk_q.seed != SEEDED) begin
                chk_d.seed = chk_q.seed + SEED_W'(1);
            end else if (count_en && mismatch && (chk_q.cnt != CNT_MAX)) begin
                chk_d.cnt = chk_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign err_cnt = chk_q.cnt;

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.cnt == CNT_MAX && !clear) |=> chk_q.cnt == CNT_MAX);

    p_no_count_seeding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && chk_q.seed != SEEDED) |=> chk_q.cnt == $past(chk_q.cnt));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> chk_q.cnt == '0);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (chk_q.cnt == $past(chk_q.cnt)) ||
                   (chk_q.cnt == $past(chk_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl #(
    parameter int PH_W   = 5,
    parameter int TH_W   = 5,
    parameter int TIME_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TIME_W-1:0]    cfg_settle,
    input  logic [TIME_W-1:0]    cfg_dwell,
    output logic [PH_W-1:0]      phase_code,
    output logic [TH_W-1:0]      thresh_code,
    output logic                 busy,
    output logic                 done,
    output logic                 chk_clear,
    output logic                 chk_count_en,
    output logic                 store_we,
    output logic [PH_W+TH_W-1:0] store_addr
);
    import prbs_eye_pkg::*;

    localparam logic [PH_W-1:0] PH_MAX = '1;
    localparam logic [TH_W-1:0] TH_MAX = '1;

    typedef struct packed {
        sweep_state_e      state;
        logic [PH_W-1:0]   ph;
        logic [TH_W-1:0]   th;
        logic [TIME_W-1:0] tmr;
        logic [TIME_W-1:0] settle;
        logic [TIME_W-1:0] dwell;
        logic              done;
    } ctrl_regs_t;

    ctrl_regs_t ctl_d, ctl_q;
    logic [TIME_W:0] tmr_next;

    assign tmr_next = {1'b0, ctl_q.tmr} + (TIME_W+1)'(1);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            SW_IDLE: begin
                if (start) begin
                    ctl_d.state  = SW_SETTLE;
                    ctl_d.ph     = '0;
                    ctl_d.th     = '0;
                    ctl_d.tmr    = '0;
                    ctl_d.done   = 1'b0;
                    ctl_d.settle = cfg_settle;
                    ctl_d.dwell  = cfg_dwell;
                end
            end
            SW_SETTLE: begin
                if (tmr_next >= {1'b0, ctl_q.settle}) begin
                    ctl_d.state = SW_DWELL;
                    ctl_d.tmr   = '0;
                end else begin
                    ctl_d.tmr = tmr_next[TIME_W-1:0];
                end
            end
            SW_DWELL: begin
                if (tmr_next >= {1'b0, ctl_q.dwell}) begin
                    ctl_d.state = SW_STORE;
                    ctl_d.tmr   = '0;
                end else begin
                    ctl_d.tmr = tmr_next[TIME_W-1:0];
                end
            end
            SW_STORE: begin
                ctl_d.tmr = '0;
                if (ctl_q.ph == PH_MAX && ctl_q.th == TH_MAX) begin
                    ctl_d.state = SW_IDLE;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.state = SW_SETTLE;
                    if (ctl_q.ph == PH_MAX) begin
                        ctl_d.ph = '0;
                        ctl_d.th = ctl_q.th + TH_W'(1);
                    end else begin
                        ctl_d.ph = ctl_q.ph + PH_W'(1);
                    end
                end
            end
            default: ctl_d.state = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: SW_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign phase_code   = ctl_q.ph;
    assign thresh_code  = ctl_q.th;
    assign busy         = (ctl_q.state != SW_IDLE);
    assign done         = ctl_q.done;
    assign chk_clear    = (ctl_q.state == SW_SETTLE) && (ctl_q.tmr == '0);
    assign chk_count_en = (ctl_q.state == SW_DWELL);
    assign store_we     = (ctl_q.state == SW_STORE);
    assign store_addr   = {ctl_q.th, ctl_q.ph};

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> ctl_q.state == SW_IDLE);

    p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == SW_SETTLE || ctl_q.state == SW_DWELL)
            |=> $stable(ctl_q.ph) && $stable(ctl_q.th));

    p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != SW_IDLE) |=> $stable(ctl_q.settle) && $stable(ctl_q.dwell));
endmodule

// File: rtl/prbs_eye_tester.sv
module prbs_eye_tester #(
    parameter int LANES      = 16,
    parameter int PH_W       = 5,
    parameter int TH_W       = 5,
    parameter int CNT_W      = 16,
    parameter int TIME_W     = 16,
    parameter int LANE_IDX_W = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cfg_ext_loop,
    input  logic [TIME_W-1:0]     cfg_settle,
    input  logic [TIME_W-1:0]     cfg_dwell,
    output logic [LANES-1:0]      tx_lanes,
    input  logic [LANES-1:0]      rx_lanes,
    output logic [PH_W-1:0]       phase_code,
    output logic [TH_W-1:0]       thresh_code,
    output logic                  loop_int,
    output logic                  loop_ext,
    output logic                  busy,
    output logic                  done,
    input  logic [LANE_IDX_W-1:0] rd_lane,
    input  logic [PH_W-1:0]       rd_phase,
    input  logic [TH_W-1:0]       rd_thresh,
    output logic [CNT_W-1:0]      rd_count
);
    localparam int ADDR_W = PH_W + TH_W;
    localparam int POINTS = 1 << ADDR_W;
    localparam int WORD_W = LANES * CNT_W;

    logic              chk_clear;
    logic              chk_count_en;
    logic              store_we;
    logic [ADDR_W-1:0] store_addr;
    logic [WORD_W-1:0] lane_counts;
    logic [WORD_W-1:0] rd_word;

    prbs7_gen #(.LANES(LANES)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_lanes (tx_lanes)
    );

    eye_sweep_ctrl #(.PH_W(PH_W), .TH_W(TH_W), .TIME_W(TIME_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_settle   (cfg_settle),
        .cfg_dwell    (cfg_dwell),
        .phase_code   (phase_code),
        .thresh_code  (thresh_code),
        .busy         (busy),
        .done         (done),
        .chk_clear    (chk_clear),
        .chk_count_en (chk_count_en),
        .store_we     (store_we),
        .store_addr   (store_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        prbs7_lane_chk #(.CNT_W(CNT_W)) u_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (chk_clear),
            .count_en (chk_count_en),
            .rx_bit   (rx_lanes[g]),
            .err_cnt  (lane_counts[g*CNT_W +: CNT_W])
        );
    end

    // result store: one word per grid point, all lanes side by side
    logic [WORD_W-1:0] result_mem [POINTS];

    always_ff @(posedge clk) begin
        if (store_we) result_mem[store_addr] <= lane_counts;
    end

    assign rd_word = result_mem[{rd_thresh, rd_phase}];

    typedef struct packed {
        logic             ext;
        logic [CNT_W-1:0] rd;
    } top_regs_t;

    top_regs_t top_d, top_q;

    always_comb begin
        top_d    = top_q;
        top_d.rd = rd_word[rd_lane*CNT_W +: CNT_W];
        if (start && !busy) top_d.ext = cfg_ext_loop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rd_count = top_q.rd;
    assign loop_int = busy & ~top_q.ext;
    assign loop_ext = busy &  top_q.ext;

    p_loop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_int, loop_ext}));

    p_loop_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(loop_ext));
endmodule

// File: tb/prbs_eye_tester_tb.sv
`timescale 1ns/1ps
module prbs_eye_tester_tb;
    localparam int LANES  = 4;
    localparam int PH_W   = 2;
    localparam int TH_W   = 2;
    localparam int CNT_W  = 4;
    localparam int TIME_W = 8;
    localparam int LIW    = 2;
    localparam int POINTS = 1 << (PH_W + TH_W);
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cfg_ext_loop = 1'b0;
    logic [TIME_W-1:0] cfg_settle = 8'd8;
    logic [TIME_W-1:0] cfg_dwell = 8'd10;
    logic [LANES-1:0]  tx_lanes;
    logic [LANES-1:0]  rx_lanes;
    logic [PH_W-1:0]   phase_code;
    logic [TH_W-1:0]   thresh_code;
    logic              loop_int, loop_ext, busy, done;
    logic [LIW-1:0]    rd_lane = '0;
    logic [PH_W-1:0]   rd_phase = '0;
    logic [TH_W-1:0]   rd_thresh = '0;
    logic [CNT_W-1:0]  rd_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    prbs_eye_tester #(
        .LANES(LANES), .PH_W(PH_W), .TH_W(TH_W), .CNT_W(CNT_W),
        .TIME_W(TIME_W), .LANE_IDX_W(LIW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_ext_loop(cfg_ext_loop),
        .cfg_settle(cfg_settle), .cfg_dwell(cfg_dwell), .tx_lanes(tx_lanes),
        .rx_lanes(rx_lanes), .phase_code(phase_code), .thresh_code(thresh_code),
        .loop_int(loop_int), .loop_ext(loop_ext), .busy(busy), .done(done),
        .rd_lane(rd_lane), .rd_phase(rd_phase), .rd_thresh(rd_thresh),
        .rd_count(rd_count)
    );

    // loopback model: lane inverted when phase+threshold exceeds lane+2;
    // lane 0 additionally delayed two cycles
    function automatic bit flips(int lane, int ph, int th);
        return (ph + th) > (lane + 2);
    endfunction

    logic [1:0] dly0;
    always @(posedge clk) dly0 <= {dly0[0], tx_lanes[0]};

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rx_lanes[i] = ((i == 0) ? dly0[1] : tx_lanes[i]) ^
                          flips(i, int'(phase_code), int'(thresh_code));
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // raster-order monitor (R6)
    int prev_addr = 0;
    int raster_bad = 0;
    always @(negedge clk) begin
        if (rst_n && busy) begin
            int a;
            a = int'({thresh_code, phase_code});
            if (a != prev_addr) begin
                if (a != prev_addr + 1) raster_bad++;
                prev_addr = a;
            end
        end
    end

    task automatic run_sweep(bit ext, int settle, int dwell, bit poke);
        int n;
        int exp_n;
        int loop_seen_int;
        int loop_seen_ext;
        @(negedge clk);
        cfg_ext_loop = ext;
        cfg_settle = TIME_W'(settle);
        cfg_dwell = TIME_W'(dwell);
        prev_addr = 0;
        raster_bad = 0;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8 done cleared by start", done, 0);
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        loop_seen_int = 0;
        loop_seen_ext = 0;
        while (!done && n < 5000) begin
            if (loop_int) loop_seen_int++;
            if (loop_ext) loop_seen_ext++;
            if (poke && n == 40) begin
                start = 1'b1;
                cfg_settle = 8'd30;
                cfg_dwell = 8'd3;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        exp_n = 1 + POINTS * (settle + dwell + 1);
        check(n == exp_n, poke ? "R9 R7 sweep length despite mid-run start"
                               : "R7 sweep length", n, exp_n);
        check(done && !busy, "R8 done and idle at end", done, 1);
        check(ext ? (loop_seen_ext > 0 && loop_seen_int == 0)
                  : (loop_seen_int > 0 && loop_seen_ext == 0),
              "R11 loopback select while busy",
              ext ? loop_seen_ext : loop_seen_int, 1);
        check(!loop_int && !loop_ext, "R11 loopback off when idle",
              int'({loop_int, loop_ext}), 0);
        check(raster_bad == 0 && prev_addr == POINTS - 1, "R6 raster order",
              raster_bad, 0);
        // read back every lane at every point (R2 R3 R4 R5 R10)
        for (int th = 0; th < (1 << TH_W); th++) begin
            for (int ph = 0; ph < (1 << PH_W); ph++) begin
                for (int ln = 0; ln < LANES; ln++) begin
                    int e;
                    e = flips(ln, ph, th) ? ((dwell > CMAX) ? CMAX : dwell) : 0;
                    rd_lane = LIW'(ln);
                    rd_phase = PH_W'(ph);
                    rd_thresh = TH_W'(th);
                    @(posedge clk);
                    @(negedge clk);
                    check(int'(rd_count) == e,
                          (e == CMAX) ? "R4 saturated count" :
                          (e == 0) ? "R2 R5 clean point reads 0 (R10)" :
                                     "R3 inverted lane counts dwell (R10)",
                          int'(rd_count), e);
                end
            end
        end
    endtask

    initial begin
        bit ok_rec;
        bit ok_eq;
        bit nonzero;
        logic hist [0:39];
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !loop_int && !loop_ext, "R12 flags at reset",
              int'({busy, done, loop_int, loop_ext}), 0);
        check(phase_code == 0 && thresh_code == 0, "R12 codes at reset",
              int'({thresh_code, phase_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R12 idle after reset release", int'({busy, done}), 0);
        // R1 transmit stream
        ok_rec = 1;
        ok_eq = 1;
        nonzero = 0;
        for (int k = 0; k < 40; k++) begin
            hist[k] = tx_lanes[0];
            if (tx_lanes != {LANES{tx_lanes[0]}}) ok_eq = 0;
            if (tx_lanes[0]) nonzero = 1;
            if (k >= 7 && hist[k] != (hist[k-7] ^ hist[k-6])) ok_rec = 0;
            @(negedge clk);
        end
        check(ok_rec, "R1 PRBS7 recurrence", ok_rec, 1);
        check(ok_eq, "R1 lanes identical", ok_eq, 1);
        check(nonzero, "R1 stream not stuck", nonzero, 1);
        // sweep 1: internal loop, no saturation
        run_sweep(1'b0, 8, 10, 1'b0);
        // sweep 2: external loop, saturation, mid-run start ignored
        run_sweep(1'b1, 8, 40, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule